// File: doc/BRIEF.md
# Level-Interrupt EOI Storm Throttle

This block sits between end-of-interrupt (EOI) handling and the redelivery path for level-triggered interrupt pins. Each EOI is a single event naming one pin. When that pin is in level mode, unmasked and still asserting its request, the interrupt would normally be redelivered at once. The block keeps a streak counter for each pin that counts such back-to-back redeliveries. A guest that never quiets its device can therefore be detected.

When a pin's streak reaches the storm limit, that one redelivery is withheld. The counter is cleared and a delay timer starts. When the delay runs out, a sweep walks every pin in ascending order and asks the delivery engine to service each pin that is still pending. This copies the slowness of real interrupt hardware, so a misbehaving guest still makes progress. The delay is a cycle-count parameter; the default is 10 ms at 100 MHz.

The controller has three states:
- IDLE: no delay pending.
- HOLD: the timer is counting.
- SWEEP: one pin is visited per cycle.

The transitions are:
- IDLE to HOLD: a pin reaches the storm limit.
- HOLD to SWEEP: the timer reaches its last count.
- SWEEP to IDLE: the last pin has been visited and no limit hit occurred during the sweep.
- SWEEP to HOLD (rearm): the last pin has been visited and a limit hit occurred during the sweep.

Top module: `eoi_storm_throttle`

## Requirements
- R1: An EOI on a level-mode pin that is masked (`mask` bit 1) or whose request bit is clear (`irr` bit 0) produces no service request and resets that pin's streak to zero.
- R2: An EOI on a level-mode, unmasked pin with its request bit set is the STORM_LIMIT-th in a row for that pin. That EOI produces no immediate request, clears the streak and arms the delay timer.
- R3: A qualifying EOI below the limit produces exactly one request: `svc_valid` is high in the cycle after the EOI is sampled, with `svc_pin` equal to the EOI pin.
- R4: The first sweep request appears DELAY_CYCLES+1 cycles after the clock edge that sampled the limit-hitting EOI. No sweep request appears earlier.
- R5: A sweep issues a request only for pins with `level_mode` = 1, `mask` = 0, `irr` = 1 and `remote_irr` = 0. Edge-mode pins (`level_mode` = 0) are skipped.
- R6: Reset drives `svc_valid` low, cancels a pending delay so that no sweep follows, and clears every streak counter.
- R7: A limit hit while the timer is already counting does not restart the timer. That pin is covered by the same sweep.
- R8: A sweep visits pins in ascending index order, one pin per cycle, with at most one request per cycle.
- R9: A limit hit during a sweep rearms the timer once the sweep finishes. A second full sweep follows DELAY_CYCLES+1 cycles after the end of the first.
- R10: An immediate redelivery has priority over a sweep in the same cycle. The sweep stalls on its current pin and resumes there in the next cycle.
- R11: An EOI on an edge-mode pin produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_valid | input | 1 | One EOI event this cycle |
| eoi_pin | input | PIN_W | Pin the EOI refers to |
| level_mode | input | NPIN | Per pin: 1 = level-triggered, 0 = edge-triggered |
| mask | input | NPIN | Per pin: 1 = masked |
| irr | input | NPIN | Per pin: 1 = request line asserted |
| remote_irr | input | NPIN | Per pin: 1 = awaiting EOI from the local interrupt controller |
| svc_valid | output | 1 | Service request to the delivery engine |
| svc_pin | output | PIN_W | Pin to service |

## Verification
The bench targets the following corner cases:

- **Streak reset (R1).** A masked or idle EOI lands in the middle of a streak. A design that fails to reset the streak withholds a redelivery too early, and the missing item shows up in the scoreboard.
- **Timer restart (R7).** A second pin hits the limit while the timer is counting. The first sweep request is then checked on its exact cycle, so a restarted timer arrives late and is caught.
- **Collision (R10).** An immediate redelivery is timed to land on the first sweep cycle. A design that drops or overwrites either request loses an item, and one that skips the stalled pin breaks the ascending order.
- **Reset and rearm (R6, R9).** A reset arrives during HOLD, and a limit hit arrives during SWEEP. The first exposes a sweep that survives reset; the second exposes a lost rearm.

// File: rtl/eoi_thr_pkg.sv
package eoi_thr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SWEEP = 2'd2
    } thr_state_e;

endpackage

// File: rtl/eoi_streak_bank.sv
module eoi_streak_bank #(
    parameter int NPIN  = 24,
    parameter int LIMIT = 10000,
    parameter int PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_valid,
    input  logic [PIN_W-1:0] eoi_pin,
    input  logic [NPIN-1:0]  level_mode,
    input  logic [NPIN-1:0]  mask,
    input  logic [NPIN-1:0]  irr,
    output logic             redeliver,
    output logic             hit
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] streak [NPIN];
    logic [CNT_W-1:0] sel_cnt;
    logic             sel_level;
    logic             sel_mask;
    logic             sel_irr;
    logic             qualify;
    logic             pending;
    logic             at_limit;

    always_comb begin
        sel_cnt   = '0;
        sel_level = 1'b0;
        sel_mask  = 1'b1;
        sel_irr   = 1'b0;
        for (int i = 0; i < NPIN; i++) begin
            if (eoi_pin == PIN_W'(i)) begin
                sel_cnt   = streak[i];
                sel_level = level_mode[i];
                sel_mask  = mask[i];
                sel_irr   = irr[i];
            end
        end
        qualify   = eoi_valid && sel_level;
        pending   = !sel_mask && sel_irr;
        at_limit  = (sel_cnt == LAST);
        hit       = qualify && pending && at_limit;
        redeliver = qualify && pending && !at_limit;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_streak
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                streak[g] <= '0;
            end else if (qualify && eoi_pin == PIN_W'(g)) begin
                streak[g] <= (pending && !at_limit) ? streak[g] + 1'b1 : '0;
            end
        end

        AST_STREAK_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            streak[g] < CNT_W'(LIMIT)); // R2

        AST_STREAK_CLEARS_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (qualify && eoi_pin == PIN_W'(g) && !pending) |=> streak[g] == '0); // R1

        AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && eoi_pin == PIN_W'(g)) |=> streak[g] == '0); // R2
    end

endmodule

// File: rtl/eoi_sweep_fsm.sv
module eoi_sweep_fsm
    import eoi_thr_pkg::*;
#(
    parameter int NPIN  = 24,
    parameter int DELAY = 1000000,
    parameter int PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             stall,
    input  logic [NPIN-1:0]  elig,
    output logic             sweep_fire,
    output logic [PIN_W-1:0] sweep_pin,
    output logic             busy
);
    localparam int TMR_W = $clog2(DELAY > 1 ? DELAY : 2);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(DELAY - 1);
    localparam logic [PIN_W-1:0] PIN_LAST = PIN_W'(NPIN - 1);

    thr_state_e       state, state_nx;
    logic [TMR_W-1:0] tmr;
    logic [PIN_W-1:0] ptr;
    logic             rearm;
    logic             sweep_end;
    logic             elig_at_ptr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        sweep_end = (state == ST_SWEEP) && !stall && (ptr == PIN_LAST);
        state_nx  = state;
        unique case (state)
            ST_IDLE:  if (hit) state_nx = ST_HOLD;
            ST_HOLD:  if (tmr == TMR_LAST) state_nx = ST_SWEEP;
            ST_SWEEP: if (sweep_end) state_nx = (rearm || hit) ? ST_HOLD : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // timer, sweep pointer and rearm flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr   <= '0;
            ptr   <= '0;
            rearm <= 1'b0;
        end else begin
            tmr <= (state == ST_HOLD && state_nx == ST_HOLD) ? tmr + 1'b1 : '0;
            if (state != ST_SWEEP)  ptr <= '0;
            else if (!stall)        ptr <= (ptr == PIN_LAST) ? '0 : ptr + 1'b1;
            if (state != ST_SWEEP || sweep_end) rearm <= 1'b0;
            else if (hit)                       rearm <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        elig_at_ptr = 1'b0;
        for (int i = 0; i < NPIN; i++) begin
            if (ptr == PIN_W'(i)) elig_at_ptr = elig[i];
        end
        sweep_fire = (state == ST_SWEEP) && !stall && elig_at_ptr;
        sweep_pin  = ptr;
        busy       = (state != ST_IDLE);
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= TMR_LAST); // R4

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && tmr != TMR_LAST) |=> (state == ST_HOLD && tmr == $past(tmr) + 1'b1)); // R7

    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && !stall && ptr != PIN_LAST) |=> (state == ST_SWEEP && ptr == $past(ptr) + 1'b1)); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && stall) |=> (state == ST_SWEEP && $stable(ptr))); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SWEEP) |-> !sweep_fire); // R4

endmodule

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle #(
    parameter int NPIN         = 24,
    parameter int STORM_LIMIT  = 10000,
    parameter int DELAY_CYCLES = 1000000,
    parameter int PIN_W        = $clog2(NPIN > 1 ? NPIN : 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_valid,
    input  logic [PIN_W-1:0] eoi_pin,
    input  logic [NPIN-1:0]  level_mode,
    input  logic [NPIN-1:0]  mask,
    input  logic [NPIN-1:0]  irr,
    input  logic [NPIN-1:0]  remote_irr,
    output logic             svc_valid,
    output logic [PIN_W-1:0] svc_pin
);
    logic             redeliver;
    logic             hit;
    logic             sweep_fire;
    logic [PIN_W-1:0] sweep_pin;
    logic             busy;
    logic [NPIN-1:0]  elig;

    assign elig = level_mode & ~mask & irr & ~remote_irr;

    eoi_streak_bank #(
        .NPIN  (NPIN),
        .LIMIT (STORM_LIMIT),
        .PIN_W (PIN_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .eoi_valid  (eoi_valid),
        .eoi_pin    (eoi_pin),
        .level_mode (level_mode),
        .mask       (mask),
        .irr        (irr),
        .redeliver  (redeliver),
        .hit        (hit)
    );

    eoi_sweep_fsm #(
        .NPIN  (NPIN),
        .DELAY (DELAY_CYCLES),
        .PIN_W (PIN_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .stall      (redeliver),
        .elig       (elig),
        .sweep_fire (sweep_fire),
        .sweep_pin  (sweep_pin),
        .busy       (busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_valid <= 1'b0;
            svc_pin   <= '0;
        end else begin
            svc_valid <= redeliver || sweep_fire;
            svc_pin   <= redeliver ? eoi_pin : sweep_pin;
        end
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(redeliver && sweep_fire)); // R10

    AST_SVC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && !$past(busy)) |-> $past(eoi_valid)); // R3

    AST_HIT_NO_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !busy) |=> !svc_valid); // R2

endmodule

// File: tb/tb_eoi_storm_throttle.sv
module tb_eoi_storm_throttle;
    localparam int NPIN  = 4;
    localparam int LIMIT = 4;
    localparam int DELAY = 20;
    localparam int PW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          eoi_valid = 1'b0;
    logic [PW-1:0] eoi_pin = '0;
    logic [NPIN-1:0] lvl = '0, msk = '0, irq = '0, rem = '0;
    logic          svc_valid;
    logic [PW-1:0] svc_pin;

    int tests = 0;
    int fails = 0;
    int mcnt [NPIN];
    int    exp_pin [$];
    string exp_req [$];

    always #5 clk = ~clk;

    eoi_storm_throttle #(.NPIN(NPIN), .STORM_LIMIT(LIMIT), .DELAY_CYCLES(DELAY), .PIN_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_pin(eoi_pin),
        .level_mode(lvl), .mask(msk), .irr(irq), .remote_irr(rem),
        .svc_valid(svc_valid), .svc_pin(svc_pin)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int p, input string req);
        exp_pin.push_back(p);
        exp_req.push_back(req);
    endtask

    // monitor: pops expected items as requests appear
    always @(negedge clk) begin
        if (rst_n && svc_valid) begin
            if (exp_pin.size() == 0) begin
                chk(1'b0, "unexpected request", int'(svc_pin), -1);
            end else begin
                int p;
                string r;
                p = exp_pin.pop_front();
                r = exp_req.pop_front();
                chk(int'(svc_pin) == p, r, int'(svc_pin), p);
            end
        end
    end

    // driver: one EOI per cycle, model predicts the outcome (R1 R2 R3 R11)
    task automatic eoi(input int p, input string req);
        if (lvl[p]) begin
            if (!msk[p] && irq[p]) begin
                if (mcnt[p] == LIMIT - 1) mcnt[p] = 0;
                else begin
                    mcnt[p]++;
                    push(p, req);
                end
            end else begin
                mcnt[p] = 0;
            end
        end
        eoi_valid = 1'b1;
        eoi_pin   = PW'(p);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < NPIN; i++) mcnt[i] = 0;
        idle(2);
        chk(svc_valid == 1'b0, "R6 reset output", int'(svc_valid), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NPIN; i++) mcnt[i] = 0;
        lvl = 4'b0111; irq = 4'b1111; msk = '0; rem = '0;
        idle(1);
        do_reset();

        // Round 1: immediate, threshold, no restart, sweep order
        for (int k = 0; k < 4; k++) eoi(0, "R3 immediate pin0");   // 4th is the hit
        for (int k = 0; k < 4; k++) eoi(1, "R7 pin1 during hold");
        idle(DELAY - 5);
        chk(exp_pin.size() == 0, "R4 nothing early", exp_pin.size(), 0);
        push(0, "R8 sweep pin0"); push(1, "R8 sweep pin1"); push(2, "R8 sweep pin2");
        idle(2);
        chk(svc_valid && svc_pin == 0, "R4 first sweep cycle", int'(svc_pin), 0);
        idle(1);
        chk(svc_valid && svc_pin == 1, "R8 ascending", int'(svc_pin), 1);
        idle(1);
        chk(svc_valid && svc_pin == 2, "R8 ascending", int'(svc_pin), 2);
        idle(1);
        chk(!svc_valid, "R5 edge pin skipped", int'(svc_valid), 0);
        idle(4);
        chk(exp_pin.size() == 0, "R7 single sweep", exp_pin.size(), 0);

        // Round 2: streak reset by mask and idle request, sweep eligibility
        eoi(0, "R3 pin0"); eoi(0, "R3 pin0");
        msk[0] = 1'b1; eoi(0, "R1 masked"); msk[0] = 1'b0;
        for (int k = 0; k < 3; k++) eoi(0, "R1 streak was reset");
        irq[0] = 1'b0; eoi(0, "R1 idle line"); irq[0] = 1'b1;
        rem[2] = 1'b1; msk[1] = 1'b1;
        for (int k = 0; k < 4; k++) eoi(0, "R1 streak reset by idle");
        push(0, "R5 sweep only eligible");
        idle(DELAY + NPIN + 4);
        chk(exp_pin.size() == 0, "R5 eligibility", exp_pin.size(), 0);
        rem = '0; msk = '0;

        // Edge-mode pin ignored
        for (int k = 0; k < 5; k++) eoi(3, "R11 edge pin");
        idle(3);
        chk(exp_pin.size() == 0, "R11 no request", exp_pin.size(), 0);

        // Reset cancels delay and clears streaks
        do_reset();
        for (int k = 0; k < 3; k++) eoi(0, "R3 prime pin0");
        for (int k = 0; k < 4; k++) eoi(1, "R2 pin1 storm");
        idle(5);
        do_reset();
        idle(DELAY + NPIN + 5);
        chk(exp_pin.size() == 0, "R6 no sweep after reset", exp_pin.size(), 0);
        for (int k = 0; k < 3; k++) eoi(0, "R6 streak cleared");
        idle(3);
        chk(exp_pin.size() == 0, "R6 counters cleared", exp_pin.size(), 0);

        // Round 3: collision and rearm (pin0 streak is now 3)
        for (int k = 0; k < 3; k++) eoi(2, "R3 prime pin2");
        eoi(0, "R2 hit pin0");
        idle(DELAY);
        eoi(1, "R10 immediate wins");
        push(0, "R10 sweep resumes"); push(1, "R10 sweep"); push(2, "R10 sweep");
        chk(svc_valid && svc_pin == 1, "R10 collision immediate", int'(svc_pin), 1);
        eoi(2, "R9 hit during sweep");
        chk(svc_valid && svc_pin == 0, "R10 stalled pin kept", int'(svc_pin), 0);
        idle(NPIN + 1);
        push(0, "R9 second sweep"); push(1, "R9 second sweep"); push(2, "R9 second sweep");
        idle(DELAY + NPIN + 6);
        chk(exp_pin.size() == 0, "R9 rearmed sweep", exp_pin.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule